// File: doc/BRIEF.md
# Lock Elision Controller

This per-core controller sits on the stream of memory operations a core issues. It turns hinted lock critical sections into hardware transactions. An atomic read-modify-write that carries the acquire hint is taken as a lock acquisition. Its compare operand is the lock's free value and its write operand is the taken value. The controller does not send that operation to memory. It opens a transaction and checks, in the following cycle, that the lock word reads free. It then keeps the taken value only in a local shadow register. While the section runs, the core's own loads of the lock address are answered from the shadow. Other cores keep seeing the lock as free.

The section ends when a store carrying the release hint writes the recorded free value back to the recorded lock address. Both lock writes are discarded and the transaction commits. Any other outcome aborts the transaction:
- the lock reads taken during the check;
- the release goes to another address or writes another value;
- a second acquire arrives while a section is open;
- the transactional unit signals an abort, which covers capacity overflow and remote writes to the lock.

An abort raises a fallback flag. The next hinted acquisition then really goes to memory, so the section makes progress under the real lock. Operations without hints are always passed through untouched.

Top module: `lock_elide_ctrl`

## Requirements
- R1: After reset, txn_begin, elide_active, txn_commit, txn_abort, fwd_hit and fallback are all 0, and mem_req equals op_valid.
- R2: In idle with fallback clear, an operation with op_kind 2'b10 (read-modify-write) and hint_acq is withheld from memory (mem_req 0 in that cycle). txn_begin is 1 for exactly the next cycle.
- R3: In the cycle txn_begin is 1, the controller compares lock_rdata with the free value (the compare operand op_cmp of the acquisition). If they are equal, elide_active becomes 1 in the next cycle. Otherwise txn_abort becomes 1 in the next cycle.
- R4: While elide_active is 1, a load (op_kind 2'b00) to the lock address gives fwd_hit 1, fwd_data equal to the taken value (op_wdata of the acquisition) and mem_req 0, all in the same cycle. A load to any other address gives fwd_hit 0 and mem_req 1.
- R5: While eliding, a store (op_kind 2'b01) with hint_rel to the lock address that writes the free value is withheld from memory. It gives txn_commit 1 for exactly the next cycle, after which the controller is idle.
- R6: While eliding, a release store whose address or data differs from the recorded lock address or free value gives txn_abort 1 in the next cycle.
- R7: While eliding, any operation carrying hint_acq gives txn_abort 1 in the next cycle.
- R8: tx_abort while txn_begin or elide_active is 1 gives txn_abort 1 in the next cycle. Without tx_abort or a release, elision continues for any number of cycles. After an abort, the shadow is empty and no forwarding occurs.
- R9: fallback is 1 from the abort cycle onward. The next hinted acquisition in idle is passed to memory (mem_req 1) without txn_begin, and it clears fallback.
- R10: Operations without the matching hint go to memory (mem_req 1) and change no state. This holds for an unhinted read-modify-write in idle and for an unhinted read-modify-write or store while eliding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A memory operation is presented |
| op_kind | input | 2 | 00 load, 01 store, 10 read-modify-write |
| op_addr | input | AW | Operation address |
| op_wdata | input | DW | Store data / value the RMW writes |
| op_cmp | input | DW | Value the RMW expects to find |
| hint_acq | input | 1 | Acquire hint |
| hint_rel | input | 1 | Release hint |
| lock_rdata | input | DW | Transactional read of the lock word, used in the check cycle |
| tx_abort | input | 1 | Abort from the transactional unit |
| mem_req | output | 1 | Operation is forwarded to memory |
| fwd_hit | output | 1 | Load answered from the local shadow |
| fwd_data | output | DW | Shadow value for a forwarded load |
| txn_begin | output | 1 | Transaction start / lock check cycle |
| elide_active | output | 1 | Critical section is being elided |
| txn_commit | output | 1 | Commit pulse |
| txn_abort | output | 1 | Abort pulse |
| fallback | output | 1 | Next acquisition takes the real lock |

## Verification
The bench sweeps lock addresses and free/taken value pairs. These include free values that differ from the taken value by one bit. For each pair it runs a clean elision and one of the abort paths. One attack is a release that matches in address but not data, or the reverse. A design comparing only one field would then commit a section that never released its lock. A lock check that reads taken is another target: a controller that ignores lock_rdata would elide a lock another core really holds. After every abort the bench sends a hinted acquisition and expects it to reach memory. A design without the fallback flag would elide again and could livelock. Forwarding is probed both on the lock address and beside it, so a shadow that answers every load, or that survives an abort, is caught.

// File: rtl/lock_elide_pkg.sv
package lock_elide_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHECK  = 3'd1,
    ST_ELIDE  = 3'd2,
    ST_COMMIT = 3'd3,
    ST_ABORT  = 3'd4
  } elide_state_e;

  localparam logic [1:0] OP_LOAD  = 2'b00;
  localparam logic [1:0] OP_STORE = 2'b01;
  localparam logic [1:0] OP_RMW   = 2'b10;
endpackage

// File: rtl/lock_shadow.sv
module lock_shadow #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          clear,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_free,
  input  logic [DW-1:0] cap_taken,
  input  logic [AW-1:0] probe_addr,
  input  logic [DW-1:0] probe_data,
  input  logic [DW-1:0] rd_data,
  output logic          addr_match,
  output logic          data_is_free,
  output logic          rd_is_free,
  output logic [DW-1:0] taken_val
);
  logic          held_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] free_q;
  logic [DW-1:0] taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (clear) begin
      held_q <= 1'b0;
    end else if (capture) begin
      held_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      free_q  <= '0;
      taken_q <= '0;
    end else if (clear) begin
      addr_q  <= '0;
      free_q  <= '0;
      taken_q <= '0;
    end else if (capture) begin
      addr_q  <= cap_addr;
      free_q  <= cap_free;
      taken_q <= cap_taken;
    end
  end

  assign addr_match   = held_q && (probe_addr == addr_q);
  assign data_is_free = (probe_data == free_q);
  assign rd_is_free   = (rd_data == free_q);
  assign taken_val    = taken_q;
endmodule

// File: rtl/elide_fsm.sv
module elide_fsm
  import lock_elide_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   op_kind,
  input  logic         hint_acq,
  input  logic         hint_rel,
  input  logic         tx_abort,
  input  logic         addr_match,
  input  logic         data_is_free,
  input  logic         rd_is_free,
  output elide_state_e state,
  output logic         capture,
  output logic         clear,
  output logic         consume,
  output logic         fallback
);
  elide_state_e state_q, state_d;
  logic         fb_q, fb_d;
  logic         acq_rmw, rel_st, fb_clr;

  assign acq_rmw = op_valid && hint_acq && (op_kind == OP_RMW);
  assign rel_st  = op_valid && hint_rel && (op_kind == OP_STORE);

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    consume = 1'b0;
    fb_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (acq_rmw) begin
          if (fb_q) begin
            fb_clr = 1'b1;
          end else begin
            capture = 1'b1;
            consume = 1'b1;
            state_d = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        state_d = (tx_abort || !rd_is_free) ? ST_ABORT : ST_ELIDE;
      end
      ST_ELIDE: begin
        if (tx_abort || (op_valid && hint_acq)) begin
          state_d = ST_ABORT;
        end else if (rel_st) begin
          if (addr_match && data_is_free) begin
            consume = 1'b1;
            state_d = ST_COMMIT;
          end else begin
            state_d = ST_ABORT;
          end
        end
      end
      ST_COMMIT: state_d = ST_IDLE;
      ST_ABORT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    fb_d = fb_q;
    if (state_d == ST_ABORT && state_q != ST_ABORT) begin
      fb_d = 1'b1;
    end else if (fb_clr) begin
      fb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fb_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fb_q    <= fb_d;
    end
  end

  assign state    = state_q;
  assign clear    = (state_q == ST_COMMIT) || (state_q == ST_ABORT);
  assign fallback = fb_q;
endmodule

// File: rtl/lock_elide_ctrl.sv
module lock_elide_ctrl
  import lock_elide_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  input  logic [DW-1:0] op_cmp,
  input  logic          hint_acq,
  input  logic          hint_rel,
  input  logic [DW-1:0] lock_rdata,
  input  logic          tx_abort,
  output logic          mem_req,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data,
  output logic          txn_begin,
  output logic          elide_active,
  output logic          txn_commit,
  output logic          txn_abort,
  output logic          fallback
);
  elide_state_e  state;
  logic          capture, clear, consume;
  logic          addr_match, data_is_free, rd_is_free;
  logic [DW-1:0] taken_val;

  elide_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .hint_acq     (hint_acq),
    .hint_rel     (hint_rel),
    .tx_abort     (tx_abort),
    .addr_match   (addr_match),
    .data_is_free (data_is_free),
    .rd_is_free   (rd_is_free),
    .state        (state),
    .capture      (capture),
    .clear        (clear),
    .consume      (consume),
    .fallback     (fallback)
  );

  lock_shadow #(.AW(AW), .DW(DW)) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (capture),
    .clear        (clear),
    .cap_addr     (op_addr),
    .cap_free     (op_cmp),
    .cap_taken    (op_wdata),
    .probe_addr   (op_addr),
    .probe_data   (op_wdata),
    .rd_data      (lock_rdata),
    .addr_match   (addr_match),
    .data_is_free (data_is_free),
    .rd_is_free   (rd_is_free),
    .taken_val    (taken_val)
  );

  assign elide_active = (state == ST_ELIDE);
  assign txn_begin    = (state == ST_CHECK);
  assign txn_commit   = (state == ST_COMMIT);
  assign txn_abort    = (state == ST_ABORT);

  assign fwd_hit  = elide_active && op_valid && (op_kind == OP_LOAD) && addr_match;
  assign fwd_data = fwd_hit ? taken_val : '0;
  assign mem_req  = op_valid && !consume && !fwd_hit;
endmodule

// File: rtl/lock_elide_chk.sv
module lock_elide_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_kind,
  input logic       hint_acq,
  input logic       tx_abort,
  input logic       mem_req,
  input logic       fwd_hit,
  input logic       txn_begin,
  input logic       elide_active,
  input logic       txn_commit,
  input logic       txn_abort,
  input logic       fallback
);
  logic idle;
  assign idle = !(txn_begin || elide_active || txn_commit || txn_abort);

  // R1
  state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({txn_begin, elide_active, txn_commit, txn_abort}));

  // R2
  acq_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !fallback && op_valid && op_kind == 2'b10 && hint_acq) |=> txn_begin);

  // R3
  check_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_begin |=> (elide_active || txn_abort));

  // R4
  fwd_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (elide_active && !mem_req));

  // R5
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_commit |=> idle);

  // R7
  nested_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elide_active && op_valid && hint_acq) |=> txn_abort);

  // R8
  ext_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((elide_active || txn_begin) && tx_abort) |=> txn_abort);

  // R8
  shadow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_abort |=> !fwd_hit);

  // R9
  fallback_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_abort |-> fallback);

  // R9
  fallback_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && fallback && op_valid && op_kind == 2'b10 && hint_acq) |-> mem_req ##1 !fallback);
endmodule

bind lock_elide_ctrl lock_elide_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_kind      (op_kind),
  .hint_acq     (hint_acq),
  .tx_abort     (tx_abort),
  .mem_req      (mem_req),
  .fwd_hit      (fwd_hit),
  .txn_begin    (txn_begin),
  .elide_active (elide_active),
  .txn_commit   (txn_commit),
  .txn_abort    (txn_abort),
  .fallback     (fallback)
);

// File: tb/lock_elide_ctrl_bench.sv
`timescale 1ns/1ps
module lock_elide_ctrl_bench;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk, rst_n;
  logic          op_valid, hint_acq, hint_rel, tx_abort;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata, op_cmp, lock_rdata;
  logic          mem_req, fwd_hit, txn_begin, elide_active, txn_commit, txn_abort, fallback;
  logic [DW-1:0] fwd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lock_elide_ctrl #(.AW(AW), .DW(DW)) u_lock_elide_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_cmp(op_cmp),
    .hint_acq(hint_acq), .hint_rel(hint_rel), .lock_rdata(lock_rdata),
    .tx_abort(tx_abort), .mem_req(mem_req), .fwd_hit(fwd_hit),
    .fwd_data(fwd_data), .txn_begin(txn_begin), .elide_active(elide_active),
    .txn_commit(txn_commit), .txn_abort(txn_abort), .fallback(fallback)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [DW-1:0] c,
                       input logic acq, input logic rel);
    op_valid = 1'b1; op_kind = k; op_addr = a; op_wdata = d; op_cmp = c;
    hint_acq = acq; hint_rel = rel;
    #0.5;
  endtask

  task automatic quiet();
    op_valid = 1'b0; hint_acq = 1'b0; hint_rel = 1'b0; tx_abort = 1'b0;
  endtask

  task automatic acquire(input logic [AW-1:0] a, input logic [DW-1:0] f,
                         input logic [DW-1:0] t, input logic [DW-1:0] rd);
    drive(2'b10, a, t, f, 1'b1, 1'b0);
    chk(mem_req == 1'b0, "R2 acquire withheld", mem_req, 0);
    tick(); quiet();
    chk(txn_begin == 1'b1, "R2 begin", txn_begin, 1);
    lock_rdata = rd;
    tick();
    chk(txn_begin == 1'b0, "R2 begin one cycle", txn_begin, 0);
  endtask

  task automatic abort_tail(input logic [AW-1:0] a, input string tag);
    chk(txn_abort == 1'b1, tag, txn_abort, 1);
    chk(fallback == 1'b1, "R9 fallback set", fallback, 1);
    tick();
    chk(txn_abort == 1'b0 && elide_active == 1'b0, "R8 back to idle", elide_active, 0);
    drive(2'b00, a, 8'h00, 8'h00, 1'b0, 1'b0);
    chk(fwd_hit == 1'b0 && mem_req == 1'b1, "R8 shadow cleared", fwd_hit, 0);
    drive(2'b10, a, 8'h01, 8'h00, 1'b1, 1'b0);
    chk(mem_req == 1'b1, "R9 fallback acquire to memory", mem_req, 1);
    tick(); quiet();
    chk(txn_begin == 1'b0, "R9 no begin under fallback", txn_begin, 0);
    chk(fallback == 1'b0, "R9 fallback cleared", fallback, 0);
  endtask

  initial begin
    quiet();
    op_kind = 2'b00; op_addr = '0; op_wdata = '0; op_cmp = '0; lock_rdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk({txn_begin, elide_active, txn_commit, txn_abort, fwd_hit, fallback} == 6'b0,
        "R1 reset outputs", {txn_begin, elide_active, txn_commit, txn_abort, fwd_hit, fallback}, 0);
    drive(2'b01, 8'h10, 8'h55, 8'h00, 1'b0, 1'b0);
    chk(mem_req == 1'b1, "R1 mem_req follows op_valid", mem_req, 1);
    quiet(); #0.5;
    chk(mem_req == 1'b0, "R1 no request when idle", mem_req, 0);

    // R10 unhinted RMW in idle
    drive(2'b10, 8'h20, 8'h01, 8'h00, 1'b0, 1'b0);
    chk(mem_req == 1'b1, "R10 unhinted rmw passes", mem_req, 1);
    tick(); quiet();
    chk(txn_begin == 1'b0, "R10 unhinted rmw no begin", txn_begin, 0);

    for (int ai = 0; ai < 16; ai++) begin
      for (int fi = 0; fi < 4; fi++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] f, t;
        a = AW'(ai * 17 + 3);
        f = (fi == 0) ? 8'h00 : (fi == 1) ? 8'h01 : (fi == 2) ? 8'h80 : 8'hFF;
        t = f ^ DW'(1 << (ai % DW));

        // clean elision
        acquire(a, f, t, f);
        chk(elide_active == 1'b1, "R3 free lock elides", elide_active, 1);
        drive(2'b00, a, 8'h00, 8'h00, 1'b0, 1'b0);
        chk(fwd_hit == 1'b1 && mem_req == 1'b0, "R4 lock load forwarded", fwd_hit, 1);
        chk(fwd_data == t, "R4 forwarded taken value", fwd_data, t);
        drive(2'b00, a ^ 8'h01, 8'h00, 8'h00, 1'b0, 1'b0);
        chk(fwd_hit == 1'b0 && mem_req == 1'b1, "R4 other load to memory", fwd_hit, 0);
        drive(2'b10, a, t, f, 1'b0, 1'b0);
        chk(mem_req == 1'b1, "R10 unhinted rmw passes while eliding", mem_req, 1);
        tick();
        chk(elide_active == 1'b1, "R10 unhinted rmw keeps elision", elide_active, 1);
        drive(2'b01, a, f, 8'h00, 1'b0, 1'b1);
        chk(mem_req == 1'b0, "R5 release withheld", mem_req, 1'b0);
        tick(); quiet();
        chk(txn_commit == 1'b1, "R5 commit", txn_commit, 1);
        tick();
        chk(txn_commit == 1'b0 && elide_active == 1'b0 && fallback == 1'b0,
            "R5 commit one cycle then idle", txn_commit, 0);

        // one abort path per point
        unique case ((ai + fi) % 5)
          0: begin
            acquire(a, f, t, f ^ 8'h01);
            abort_tail(a, "R3 taken lock aborts");
          end
          1: begin
            acquire(a, f, t, f);
            drive(2'b01, a ^ 8'h04, f, 8'h00, 1'b0, 1'b1);
            tick(); quiet();
            abort_tail(a, "R6 release wrong address");
          end
          2: begin
            acquire(a, f, t, f);
            drive(2'b01, a, f ^ 8'h02, 8'h00, 1'b0, 1'b1);
            tick(); quiet();
            abort_tail(a, "R6 release wrong data");
          end
          3: begin
            acquire(a, f, t, f);
            drive(2'b10, a ^ 8'h08, 8'h01, 8'h00, 1'b1, 1'b0);
            tick(); quiet();
            abort_tail(a, "R7 nested acquire aborts");
          end
          default: begin
            acquire(a, f, t, f);
            repeat (20) tick();
            chk(elide_active == 1'b1, "R8 elision persists without release", elide_active, 1);
            tx_abort = 1'b1;
            tick(); quiet();
            abort_tail(a, "R8 external abort");
          end
        endcase
      end
    end

    // R8 external abort during the check cycle
    drive(2'b10, 8'h44, 8'h01, 8'h00, 1'b1, 1'b0);
    tick(); quiet();
    lock_rdata = 8'h00; tx_abort = 1'b1;
    tick(); quiet();
    abort_tail(8'h44, "R8 abort during check");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule